// File: doc/BRIEF.md
# Delegating Interrupt Pending Selector

This block decides which local interrupt a hart should take next. It holds the pending vector in a register of its own, which software-facing logic or interrupt sources update through a masked write port. A write replaces only the bits selected by the mask and returns, in the same cycle, the value the register held before the write. A hard-request line tracks whether any bit of the pending register is set. It rises when the register leaves zero and falls when the register returns to zero.

Each cycle the block ANDs the pending register with the enable vector to form the candidates. Each candidate is then gated by one of two rules, chosen by its delegation bit. A delegated source follows the supervisor rule and any other source follows the machine rule. The lowest-numbered candidate that survives is registered as the selected interrupt, together with a take flag.

Privilege is a 2-bit code: user is 0, supervisor is 1 and machine is 3. The code 2 is handled as user.

Top module: `intr_pick`

## Requirements
- R1: During reset and in the first cycle after it, `pend_q`, `irq_req`, `take` and `take_id` are all zero.
- R2: On a clock edge with `pend_wr_en` high, `pend_q` becomes `(old & ~pend_wr_mask) | (pend_wr_data & pend_wr_mask)`. On an edge with `pend_wr_en` low, `pend_q` keeps its value.
- R3: `pend_old` always shows the pending register's value before any write in the current cycle takes effect.
- R4: `irq_req` is registered together with the pending register. It is set when the register goes from zero to nonzero, cleared when it goes from nonzero to zero, and held otherwise.
- R5: Candidates are `pend_q & int_en`. When no candidate passes its gate, `take` is 0 and `take_id` is 0.
- R6: A candidate whose `deleg` bit is 0 passes when the privilege is below machine (code 0 or 1), or when the privilege is machine (code 3) and `m_gie` is 1.
- R7: A candidate whose `deleg` bit is 1 passes only when the privilege is user, or when the privilege is supervisor and `s_gie` is 1. A delegated candidate never passes at machine privilege.
- R8: Privilege code 2 gates exactly like code 0.
- R9: When one or more candidates pass, `take` is 1 and `take_id` is the lowest passing bit index.
- R10: `take` and `take_id` reflect the `pend_q`, `int_en`, `deleg`, `priv`, `m_gie` and `s_gie` values present at the previous clock edge. A pending write therefore reaches `take` two edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_wr_en | input | 1 | Apply a masked write to the pending register |
| pend_wr_mask | input | NUM_SRC | Bits to replace |
| pend_wr_data | input | NUM_SRC | New values for the masked bits |
| pend_old | output | NUM_SRC | Pending value before this cycle's write |
| pend_q | output | NUM_SRC | Current pending register |
| irq_req | output | 1 | Hard-request line, high while pending is nonzero |
| int_en | input | NUM_SRC | Per-source enable |
| deleg | input | NUM_SRC | Per-source delegation to supervisor |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 2 as user, 3 machine) |
| m_gie | input | 1 | Global machine enable |
| s_gie | input | 1 | Global supervisor enable |
| take | output | 1 | An interrupt is selected |
| take_id | output | $clog2(NUM_SRC) | Selected source index |

## Verification
The bench builds the block with the default of 32 sources and a 5-bit index. At this width, both edge indices (0 and 31) are reachable, and a pending write can flip the register between all-zero and all-ones in one cycle. The random phase spreads writes, enables, delegation masks and all four privilege codes across 32 bits. As a result, the delegated and non-delegated gates compete for the lowest index in many patterns. The directed cases pin the machine-mode and supervisor-mode enable corners and the code-2 alias.

// File: rtl/intr_pick_pkg.sv
package intr_pick_pkg;
  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPV  = 2'd1;
  localparam logic [1:0] PRIV_RSVD  = 2'd2;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  // Code 2 is folded onto user level.
  function automatic logic [1:0] fold_priv(input logic [1:0] p);
    return (p == PRIV_RSVD) ? PRIV_USER : p;
  endfunction

  function automatic logic mach_gate_open(input logic [1:0] p, input logic gie);
    logic [1:0] f;
    f = fold_priv(p);
    return (f != PRIV_MACH) || gie;
  endfunction

  function automatic logic supv_gate_open(input logic [1:0] p, input logic gie);
    logic [1:0] f;
    f = fold_priv(p);
    return (f == PRIV_USER) || ((f == PRIV_SUPV) && gie);
  endfunction
endpackage

// File: rtl/intr_pend_reg.sv
module intr_pend_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_mask,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] old_val,
  output logic [N-1:0] cur_val,
  output logic         req
);
  logic [N-1:0] val_q;
  logic [N-1:0] merged;
  logic         became_set;
  logic         became_clear;

  assign merged       = (val_q & ~wr_mask) | (wr_data & wr_mask);
  assign became_set   = wr_en && (val_q == '0) && (merged != '0);
  assign became_clear = wr_en && (val_q != '0) && (merged == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      req   <= 1'b0;
    end else begin
      if (wr_en) val_q <= merged;
      if (became_set)        req <= 1'b1;
      else if (became_clear) req <= 1'b0;
    end
  end

  assign old_val = val_q;
  assign cur_val = val_q;
endmodule

// File: rtl/intr_gate.sv
module intr_gate #(
  parameter int N = 32
) (
  input  logic [N-1:0] cand,
  input  logic [N-1:0] deleg,
  input  logic [1:0]   priv,
  input  logic         m_gie,
  input  logic         s_gie,
  output logic [N-1:0] passed
);
  import intr_pick_pkg::*;
  logic m_open;
  logic s_open;

  assign m_open = mach_gate_open(priv, m_gie);
  assign s_open = supv_gate_open(priv, s_gie);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign passed[i] = cand[i] && (deleg[i] ? s_open : m_open);
  end
endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
  parameter int N   = 32,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   vec,
  output logic           any,
  output logic [IDW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/intr_pick.sv
module intr_pick #(
  parameter int NUM_SRC = 32,
  localparam int IDW    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pend_wr_en,
  input  logic [NUM_SRC-1:0] pend_wr_mask,
  input  logic [NUM_SRC-1:0] pend_wr_data,
  output logic [NUM_SRC-1:0] pend_old,
  output logic [NUM_SRC-1:0] pend_q,
  output logic               irq_req,
  input  logic [NUM_SRC-1:0] int_en,
  input  logic [NUM_SRC-1:0] deleg,
  input  logic [1:0]         priv,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic               take,
  output logic [IDW-1:0]     take_id
);
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] gated;
  logic               sel_any;
  logic [IDW-1:0]     sel_idx;

  intr_pend_reg #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .wr_en(pend_wr_en), .wr_mask(pend_wr_mask),
    .wr_data(pend_wr_data), .old_val(pend_old), .cur_val(pend_q), .req(irq_req)
  );

  assign cand = pend_q & int_en;

  intr_gate #(.N(NUM_SRC)) u_gate (
    .cand(cand), .deleg(deleg), .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
    .passed(gated)
  );

  intr_prio #(.N(NUM_SRC), .IDW(IDW)) u_prio (
    .vec(gated), .any(sel_any), .idx(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take    <= 1'b0;
      take_id <= '0;
    end else begin
      take    <= sel_any;
      take_id <= sel_idx;
    end
  end
endmodule

// File: rtl/intr_pick_chk.sv
module intr_pick_chk #(
  parameter int NUM_SRC = 32,
  parameter int IDW     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pend_wr_en,
  input logic [NUM_SRC-1:0] pend_wr_mask,
  input logic [NUM_SRC-1:0] pend_wr_data,
  input logic [NUM_SRC-1:0] pend_q,
  input logic               irq_req,
  input logic [NUM_SRC-1:0] int_en,
  input logic [1:0]         priv,
  input logic               m_gie,
  input logic               take,
  input logic [IDW-1:0]     take_id
);
  logic [NUM_SRC-1:0] cand_d;
  always_ff @(posedge clk) begin
    if (!rst_n) cand_d <= '0;
    else        cand_d <= pend_q & int_en;
  end

  assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend_wr_en) |-> pend_q == (($past(pend_q) & ~$past(pend_wr_mask)) |
                                     ($past(pend_wr_data) & $past(pend_wr_mask))));

  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pend_wr_en) |-> $stable(pend_q));

  assert_req_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(pend_q) == '0) && (pend_q != '0));

  assert_req_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req) |-> ($past(pend_q) != '0) && (pend_q == '0));

  assert_take_has_cand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> cand_d[take_id]);

  assert_mach_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(priv) == 2'd3 && !$past(m_gie)) |-> !take);

  assert_idle_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> take_id == '0);
endmodule

bind intr_pick intr_pick_chk #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_wr_en(pend_wr_en), .pend_wr_mask(pend_wr_mask),
  .pend_wr_data(pend_wr_data), .pend_q(pend_q), .irq_req(irq_req), .int_en(int_en),
  .priv(priv), .m_gie(m_gie), .take(take), .take_id(take_id)
);

// File: tb/intr_pick_bench.sv
module intr_pick_bench;
  localparam int N = 32;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pend_wr_en;
  logic [N-1:0] pend_wr_mask, pend_wr_data, pend_old, pend_q, int_en, deleg;
  logic         irq_req, m_gie, s_gie, take;
  logic [1:0]   priv;
  logic [W-1:0] take_id;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] model_pend = '0;
  logic         model_req  = 1'b0;

  always #10 clk = ~clk;

  intr_pick #(.NUM_SRC(N)) u_intr_pick (
    .clk(clk), .rst_n(rst_n), .pend_wr_en(pend_wr_en), .pend_wr_mask(pend_wr_mask),
    .pend_wr_data(pend_wr_data), .pend_old(pend_old), .pend_q(pend_q), .irq_req(irq_req),
    .int_en(int_en), .deleg(deleg), .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
    .take(take), .take_id(take_id)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected selection: bit [W] = found, [W-1:0] = index.
  function automatic logic [W:0] expect_pick(input logic [N-1:0] p, input logic [N-1:0] e,
      input logic [N-1:0] d, input logic [1:0] pv, input logic mg, input logic sg);
    logic is_m, is_s;
    logic m_ok, s_ok;
    is_m = (pv == 2'd3);
    is_s = (pv == 2'd1);
    m_ok = is_m ? mg : 1'b1;
    s_ok = is_m ? 1'b0 : (is_s ? sg : 1'b1);
    for (int b = 0; b < N; b++) begin
      if (p[b] && e[b] && (d[b] ? s_ok : m_ok)) return {1'b1, W'(b)};
    end
    return '0;
  endfunction

  task automatic step(input logic we, input logic [N-1:0] mk, input logic [N-1:0] dt,
      input logic [N-1:0] en, input logic [N-1:0] dl, input logic [1:0] pv,
      input logic mg, input logic sg, input string req);
    logic [W:0] exp;
    logic [N-1:0] nxt;
    pend_wr_en = we; pend_wr_mask = mk; pend_wr_data = dt;
    int_en = en; deleg = dl; priv = pv; m_gie = mg; s_gie = sg;
    #1;
    chk("R3 pend_old", pend_old, model_pend);
    exp = expect_pick(model_pend, en, dl, pv, mg, sg);
    nxt = we ? ((model_pend & ~mk) | (dt & mk)) : model_pend;
    if (model_pend == '0 && nxt != '0) model_req = 1'b1;
    else if (model_pend != '0 && nxt == '0) model_req = 1'b0;
    model_pend = nxt;
    @(posedge clk); @(negedge clk);
    chk("R2 pend_q", pend_q, model_pend);
    chk("R4 irq_req", N'(irq_req), N'(model_req));
    chk({req, " take"}, N'(take), N'(exp[W]));
    chk({req, " take_id"}, N'(take_id), N'(exp[W-1:0]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    pend_wr_en = 0; pend_wr_mask = '0; pend_wr_data = '0;
    int_en = '1; deleg = '0; priv = 2'd3; m_gie = 1; s_gie = 1;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk("R1 pend_q", pend_q, '0);
    chk("R1 irq_req", N'(irq_req), '0);
    chk("R1 take", N'(take), '0);
    chk("R1 take_id", N'(take_id), '0);
    rst_n = 1'b1;
    step(0, '0, '0, '1, '0, 2'd3, 1, 1, "R1");
    // R2/R4: write bits 31 and 0, request rises
    step(1, 32'h8000_0001, '1, '1, '0, 2'd3, 1, 1, "R10");
    // R10: the write is now visible at take, lowest index 0 (R9)
    step(0, '0, '0, '1, '0, 2'd3, 1, 1, "R9");
    // R6: machine privilege, global machine enable off
    step(0, '0, '0, '1, '0, 2'd3, 0, 1, "R6");
    // R7: delegated source at machine privilege never passes
    step(0, '0, '0, '1, '1, 2'd3, 1, 1, "R7");
    // R7: supervisor with s_gie low blocks delegated bit 0; bit 31 undelegated wins
    step(0, '0, '0, '1, 32'h0000_0001, 2'd1, 0, 0, "R7");
    step(0, '0, '0, '1, 32'h0000_0001, 2'd1, 0, 1, "R7");
    // R6: supervisor, non-delegated passes with m_gie low
    step(0, '0, '0, '1, '0, 2'd1, 0, 0, "R6");
    // R8: code 2 behaves as user: delegated passes regardless of s_gie
    step(0, '0, '0, '1, '1, 2'd2, 0, 0, "R8");
    step(0, '0, '0, '1, '1, 2'd0, 0, 0, "R8");
    // R5: enable mask removes every candidate
    step(0, '0, '0, 32'h7FFF_FFFE, '0, 2'd0, 1, 1, "R5");
    // R9: only bit 31 left
    step(0, '0, '0, 32'h8000_0000, '0, 2'd0, 1, 1, "R9");
    // R2: unmasked bits untouched, clear bit 0 only
    step(1, 32'h0000_0001, '0, '1, '0, 2'd0, 1, 1, "R9");
    // R4: clear to zero, request falls; R5 then no take
    step(1, '1, '0, '1, '0, 2'd0, 1, 1, "R5");
    step(0, '0, '0, '1, '0, 2'd0, 1, 1, "R5");
    // Random phase
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] sparse;
      sparse = $urandom() & $urandom();
      step(($urandom() % 3) != 0, $urandom(), (k % 5 == 0) ? sparse : $urandom(),
           $urandom() | sparse, $urandom(), 2'($urandom()), 1'($urandom()),
           1'($urandom()), "R9 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule